// File: doc/BRIEF.md
# Holdover history update controller

This block gates the moment a clock-synchronizer PLL may begin merging its long-term frequency estimate into the stored device holdover history. Merging is allowed only after the loop has stayed synchronized to its chosen reference for a settling interval. That interval grows with the loop bandwidth: a narrower loop needs longer to settle. Any disturbance cancels the merge and forces the whole settling interval to run again. The disturbances are a reference change, a signal or lock loss, leaving external-timing operation, or a flush of the long-term history.

The block also reports whether the holdover logic draws on the user-written history instead of the device history. It holds that user history word so that software can read it back.

Time is measured in one-second ticks supplied from outside. The update-enable output `dht_o` tells the accumulator datapath to keep folding the long-term history into the device history.

Top module: `hist_upd_ctrl`

## Requirements
- R1: With bandwidth code 0, 1, 2, 3, 4 or 5 on `bw_code_i`, the settling time is 8, 16, 32, 64, 128 or 256 ticks respectively.
- R2: Any bandwidth code from 6 to 15 gives a settling time of 256 ticks.
- R3: `dht_o` rises in the cycle after the tick that completes the settling count of uninterrupted synchronized external-timing operation, and not earlier. It then stays 1 while no stop condition is present.
- R4: A one-cycle pulse on `ref_switch_i`, `los_i` or `lol_i` clears `dht_o` on the next edge and resets the settling count, so the full settling time must elapse again.
- R5: `mode_i` other than 2'b00 (external timing) clears `dht_o` and resets the count. The encodings are 2'b01 freerun, 2'b10 holdover, and 2'b11 treated as non-external.
- R6: `sync_i` low clears `dht_o` and resets the count.
- R7: A pulse on `flush_wr_i` clears `dht_o`, resets the count, and drives `lt_clear_o` high in the same cycle.
- R8: `hha_o` equals `hist_sel_user_i` delayed by one clock.
- R9: When `uhist_we_i` is high at an edge, `uhist_o` shows `uhist_wdata_i` from the next cycle and keeps it until the next write.
- R10: After reset, `dht_o`, `hha_o` and `uhist_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bw_code_i | input | CODE_W | Loop bandwidth code |
| sync_i | input | 1 | Loop synchronized to selected reference |
| ref_switch_i | input | 1 | Selected reference changed (pulse) |
| los_i | input | 1 | Loss of signal on selected reference |
| lol_i | input | 1 | Loss of lock |
| mode_i | input | 2 | Operating mode: 00 external, 01 freerun, 10 holdover |
| flush_wr_i | input | 1 | Write to the history flush register |
| hist_sel_user_i | input | 1 | Holdover source is the user history |
| tick_i | input | 1 | One-second tick |
| uhist_we_i | input | 1 | User history write strobe |
| uhist_wdata_i | input | HIST_W | User history write data |
| dht_o | output | 1 | Device history update enabled |
| hha_o | output | 1 | User history active |
| lt_clear_o | output | 1 | Clear long-term history |
| uhist_o | output | HIST_W | User history read-back |

## Verification
The hardest case to reach is a stop event arriving after a long settling run, followed by a proof that no leftover count shortens the next run. The stimulus first settles the loop fully with each event type in turn. It then pulses the event and issues exactly one tick fewer than the settling time, expecting `dht_o` still low. One more tick must raise it. The bandwidth sweep covers all sixteen codes, and each is checked at one tick short of the limit and then at the limit itself.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    MODE_EXT  = 2'b00,
    MODE_FREE = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_RSVD = 2'b11
  } op_mode_e;
endpackage

// File: rtl/hist_settle_lut.sv
module hist_settle_lut #(
  parameter int CODE_W   = 4,
  parameter int BASE_SEC = 8,
  parameter int MAX_STEP = 5,
  parameter int LIM_W    = 9
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LIM_W-1:0]  limit_o
);
  localparam int NCODE = 1 << CODE_W;

  logic [LIM_W-1:0] tbl [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tbl
    localparam int SH = (g > MAX_STEP) ? MAX_STEP : g;
    assign tbl[g] = LIM_W'(BASE_SEC << SH);
  end

  assign limit_o = tbl[code_i];
endmodule

// File: rtl/hist_settle_timer.sv
module hist_settle_timer #(
  parameter int LIM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             done_o
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_nxt;
  logic             done_q;

  assign cnt_nxt = cnt_q + LIM_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (kill_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt >= limit_i) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/hist_upd_ctrl.sv
module hist_upd_ctrl
  import hist_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int BASE_SEC = 8,
  parameter int MAX_STEP = 5,
  parameter int HIST_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] bw_code_i,
  input  logic              sync_i,
  input  logic              ref_switch_i,
  input  logic              los_i,
  input  logic              lol_i,
  input  logic [1:0]        mode_i,
  input  logic              flush_wr_i,
  input  logic              hist_sel_user_i,
  input  logic              tick_i,
  input  logic              uhist_we_i,
  input  logic [HIST_W-1:0] uhist_wdata_i,
  output logic              dht_o,
  output logic              hha_o,
  output logic              lt_clear_o,
  output logic [HIST_W-1:0] uhist_o
);
  localparam int MAX_LIM = BASE_SEC << MAX_STEP;
  localparam int LIM_W   = $clog2(MAX_LIM) + 1;

  logic [LIM_W-1:0]  limit;
  logic              kill;
  logic              hha_q;
  logic [HIST_W-1:0] uhist_q;

  // any stop condition restarts settling
  assign kill = ref_switch_i | los_i | lol_i | flush_wr_i | !sync_i
              | (op_mode_e'(mode_i) != MODE_EXT);

  hist_settle_lut #(
    .CODE_W  (CODE_W),
    .BASE_SEC(BASE_SEC),
    .MAX_STEP(MAX_STEP),
    .LIM_W   (LIM_W)
  ) u_lut (
    .code_i (bw_code_i),
    .limit_o(limit)
  );

  hist_settle_timer #(
    .LIM_W(LIM_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kill_i (kill),
    .tick_i (tick_i),
    .limit_i(limit),
    .done_o (dht_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hha_q   <= 1'b0;
      uhist_q <= '0;
    end else begin
      hha_q <= hist_sel_user_i;
      if (uhist_we_i) uhist_q <= uhist_wdata_i;
    end
  end

  assign hha_o      = hha_q;
  assign uhist_o    = uhist_q;
  assign lt_clear_o = flush_wr_i;
endmodule

// File: rtl/hist_upd_chk.sv
module hist_upd_chk #(
  parameter int CODE_W   = 4,
  parameter int BASE_SEC = 8,
  parameter int MAX_STEP = 5,
  parameter int HIST_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] bw_code_i,
  input logic              sync_i,
  input logic              ref_switch_i,
  input logic              los_i,
  input logic              lol_i,
  input logic [1:0]        mode_i,
  input logic              flush_wr_i,
  input logic              hist_sel_user_i,
  input logic              tick_i,
  input logic              uhist_we_i,
  input logic [HIST_W-1:0] uhist_wdata_i,
  input logic              dht_o,
  input logic              hha_o,
  input logic [HIST_W-1:0] uhist_o
);
  logic ev_stop;
  logic kill_c;
  int unsigned ticks_c;
  int unsigned lim_c;

  assign ev_stop = ref_switch_i | los_i | lol_i | flush_wr_i;
  assign kill_c  = ev_stop | !sync_i | (mode_i != 2'b00);
  assign lim_c   = BASE_SEC << ((int'(bw_code_i) > MAX_STEP) ? MAX_STEP : int'(bw_code_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ticks_c <= 0;
    else if (kill_c) ticks_c <= 0;
    else if (tick_i && ticks_c < 100000) ticks_c <= ticks_c + 1;
  end

  p_settle_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dht_o) |-> ticks_c >= lim_c);

  p_dht_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dht_o && !kill_c) |=> dht_o);

  p_event_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop |=> !dht_o);

  p_mode_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |=> !dht_o);

  p_sync_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> !dht_o);

  p_hha_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hha_o == $past(hist_sel_user_i));

  p_uhist_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uhist_we_i |=> uhist_o == $past(uhist_wdata_i));

  p_uhist_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uhist_we_i |=> $stable(uhist_o));
endmodule

bind hist_upd_ctrl hist_upd_chk #(
  .CODE_W  (CODE_W),
  .BASE_SEC(BASE_SEC),
  .MAX_STEP(MAX_STEP),
  .HIST_W  (HIST_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bw_code_i      (bw_code_i),
  .sync_i         (sync_i),
  .ref_switch_i   (ref_switch_i),
  .los_i          (los_i),
  .lol_i          (lol_i),
  .mode_i         (mode_i),
  .flush_wr_i     (flush_wr_i),
  .hist_sel_user_i(hist_sel_user_i),
  .tick_i         (tick_i),
  .uhist_we_i     (uhist_we_i),
  .uhist_wdata_i  (uhist_wdata_i),
  .dht_o          (dht_o),
  .hha_o          (hha_o),
  .uhist_o        (uhist_o)
);

// File: tb/hist_upd_ctrl_test.sv
module hist_upd_ctrl_test;
  localparam int HIST_W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] bw_code_i = '0;
  logic sync_i = 1'b0, ref_switch_i = 1'b0, los_i = 1'b0, lol_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic flush_wr_i = 1'b0, hist_sel_user_i = 1'b0, tick_i = 1'b0;
  logic uhist_we_i = 1'b0;
  logic [HIST_W-1:0] uhist_wdata_i = '0;
  logic dht_o, hha_o, lt_clear_o;
  logic [HIST_W-1:0] uhist_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hist_upd_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bw_code_i(bw_code_i), .sync_i(sync_i),
    .ref_switch_i(ref_switch_i), .los_i(los_i), .lol_i(lol_i), .mode_i(mode_i),
    .flush_wr_i(flush_wr_i), .hist_sel_user_i(hist_sel_user_i), .tick_i(tick_i),
    .uhist_we_i(uhist_we_i), .uhist_wdata_i(uhist_wdata_i), .dht_o(dht_o),
    .hha_o(hha_o), .lt_clear_o(lt_clear_o), .uhist_o(uhist_o)
  );

  task automatic chk(input string req, input logic [HIST_W-1:0] act, input logic [HIST_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int settle(input int code);
    return 8 << ((code > 5) ? 5 : code);
  endfunction

  // restart via flush, then walk to one short of the limit and to the limit
  task automatic settle_run(input string req, input int code);
    @(negedge clk_i) begin bw_code_i = 4'(code); flush_wr_i = 1'b1; end
    @(negedge clk_i) flush_wr_i = 1'b0;
    ticks(settle(code) - 1);
    chk(req, HIST_W'(dht_o), 0);
    tick();
    chk(req, HIST_W'(dht_o), 1);
  endtask

  // settle at code 0, apply a stop, verify full restart is required
  task automatic stop_case(input string req, input int which);
    settle_run(req, 0);
    @(negedge clk_i) begin
      case (which)
        0: ref_switch_i = 1'b1;
        1: los_i = 1'b1;
        2: lol_i = 1'b1;
        3: mode_i = 2'b01;
        4: mode_i = 2'b10;
        5: mode_i = 2'b11;
        6: sync_i = 1'b0;
        default: flush_wr_i = 1'b1;
      endcase
      tick_i = 1'b1;
    end
    #1;
    if (which == 7) chk("R7 lt_clear", HIST_W'(lt_clear_o), 1);
    @(negedge clk_i) begin
      chk(req, HIST_W'(dht_o), 0);
      ref_switch_i = 1'b0; los_i = 1'b0; lol_i = 1'b0; mode_i = 2'b00;
      sync_i = 1'b1; flush_wr_i = 1'b0; tick_i = 1'b0;
    end
    #1 chk("R7 lt_clear idle", HIST_W'(lt_clear_o), 0);
    ticks(7);
    chk(req, HIST_W'(dht_o), 0);
    tick();
    chk(req, HIST_W'(dht_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 dht", HIST_W'(dht_o), 0);
    chk("R10 hha", HIST_W'(hha_o), 0);
    chk("R10 uhist", uhist_o, 0);

    // not synchronized: ticks must not enable update
    ticks(20);
    chk("R6 unsync", HIST_W'(dht_o), 0);
    sync_i = 1'b1;

    for (int c = 0; c < 6; c++) settle_run("R1", c);
    for (int c = 6; c < 16; c++) settle_run("R2", c);

    // sticky while undisturbed
    repeat (10) @(negedge clk_i);
    chk("R3 sticky", HIST_W'(dht_o), 1);

    stop_case("R4 ref_switch", 0);
    stop_case("R4 los", 1);
    stop_case("R4 lol", 2);
    stop_case("R5 freerun", 3);
    stop_case("R5 holdover", 4);
    stop_case("R5 rsvd", 5);
    stop_case("R6 sync", 6);
    stop_case("R7 flush", 7);

    for (int v = 0; v < 4; v++) begin
      @(negedge clk_i) hist_sel_user_i = v[0];
      @(negedge clk_i) chk("R8 hha", HIST_W'(hha_o), HIST_W'(v[0]));
    end

    for (int k = 0; k < 4; k++) begin
      logic [HIST_W-1:0] w;
      w = 32'hA5C3_0000 + 32'(k * 32'h1357);
      @(negedge clk_i) begin uhist_we_i = 1'b1; uhist_wdata_i = w; end
      @(negedge clk_i) begin uhist_we_i = 1'b0; uhist_wdata_i = ~w; end
      chk("R9 write", uhist_o, w);
      @(negedge clk_i) chk("R9 hold", uhist_o, w);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule